// File: doc/BRIEF.md
# Page-Offset-Indexed, Frame-Tagged Data Cache

This block is a small direct-mapped data cache that sits beside an address-translation buffer. The set index is taken only from the untranslated page-offset bits of the virtual address. The array can therefore be read while translation is still under way. When the translated physical frame number arrives later in the same cycle, it is compared against the frame number stored with the line, and hit or miss is decided before the cycle ends. Read results are combinational with respect to the request inputs.

The array holds 1024 words of 4 bytes each (4 KB). Each entry keeps a valid flag, a 20-bit frame tag and a 32-bit data word. Stores are write-through and do not allocate on a miss. Every translated store is also presented to memory on a write port in the same cycle. Memory returns whole words on a fill port, and a fill installs data, tag and the valid flag in a single clock edge. Requests flagged uncached never touch the array. Index width plus byte-displacement width is fixed to the 12-bit page offset, so the overlap with translation is always complete.

Top module: `vipt_cache`

## Requirements
- R1: After a synchronous reset every entry is invalid, so any lookup that follows reports a miss until that entry has been filled.
- R2: The entry is selected by virtual address bits [11:2]. Bits [1:0] pick a byte within the word and do not affect which entry is selected. Different values of bits [11:2] reach different entries, including indices 0 and 1023.
- R3: `hit` is 1 only when the selected entry is valid, its stored frame tag equals `tlb_pfn`, and the request is a cached request with `tlb_hit` = 1. A mismatching frame on the same index gives a miss.
- R4: When `tlb_hit` = 0 the access is a miss, even if the entry is valid and its tag matches `tlb_pfn`.
- R5: A fill writes data, frame tag and valid at one clock edge. A lookup to that index in the very next cycle, with the matching frame, hits and returns the filled word.
- R6: A store that hits updates only the bytes whose `req_be` bit is set. Bit i covers data bits [8i+7:8i]. The other bytes keep their old values.
- R7: A store that misses does not allocate. A later read to that index and frame still misses.
- R8: In the same cycle as a store request with `tlb_hit` = 1, `mem_wr_valid` is 1, `mem_wr_addr` = {`tlb_pfn`, `req_vaddr_lo`}, and `mem_wr_be` and `mem_wr_data` equal the request's. A store with `tlb_hit` = 0 is not forwarded.
- R9: An uncached request never hits. An uncached store does not change the array, though it is still forwarded to memory.
- R10: When a fill and a store hit target the same index in the same cycle, the fill data is what the entry holds afterwards.
- R11: `rd_data` is zero whenever `hit` is 0.
- R12: `miss` is 1 exactly when `req_valid` is 1 and `hit` is 0. With no request, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_uncached | input | 1 | Access bypasses the array |
| req_vaddr_lo | input | 12 | Page-offset bits of the virtual address |
| req_be | input | 4 | Byte enables for a store |
| req_wdata | input | 32 | Store data |
| tlb_hit | input | 1 | Translation succeeded this cycle |
| tlb_pfn | input | 20 | Translated physical frame number |
| rd_data | output | 32 | Load data, zero unless hit |
| hit | output | 1 | Cached access found its word |
| miss | output | 1 | Request present but not a hit |
| mem_wr_valid | output | 1 | Store forwarded to memory |
| mem_wr_addr | output | 32 | Physical byte address of the forwarded store |
| mem_wr_be | output | 4 | Byte enables of the forwarded store |
| mem_wr_data | output | 32 | Data of the forwarded store |
| fill_valid | input | 1 | Fill word from memory present |
| fill_index | input | 10 | Entry to be filled |
| fill_pfn | input | 20 | Frame tag to install |
| fill_data | input | 32 | Word to install |

## Verification
Lookups are issued with the same index under the matching frame, a different frame, and a failed translation. Together these separate the tag compare from the valid flag and from the translation-hit gate. Partial byte-enable stores on a resident line, stores to an absent line, and uncached accesses to a resident line each show whether the array is updated, left alone or bypassed, and the memory-side write port is checked on each of them. The extreme indices, a fill followed immediately by a read, and a fill colliding with a store hit on one entry expose index slicing, same-cycle visibility and write priority.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int PAGE_BITS   = 12;
    localparam int WORD_BYTES  = 4;
    localparam int PFN_BITS    = 20;
    localparam int WORD_BITS   = WORD_BYTES * 8;
    localparam int OFFSET_BITS = $clog2(WORD_BYTES);
    // Index is whatever the page offset leaves after the byte displacement,
    // so the set select never depends on translated bits.
    localparam int INDEX_BITS  = PAGE_BITS - OFFSET_BITS;
    localparam int SETS        = 1 << INDEX_BITS;
    localparam int PADDR_BITS  = PFN_BITS + PAGE_BITS;

    typedef logic [INDEX_BITS-1:0] idx_t;
    typedef logic [PFN_BITS-1:0]   pfn_t;
    typedef logic [WORD_BITS-1:0]  word_t;
    typedef logic [WORD_BYTES-1:0] be_t;
    typedef logic [PAGE_BITS-1:0]  page_off_t;
    typedef logic [PADDR_BITS-1:0] paddr_t;

    typedef struct packed {
        logic  valid;
        pfn_t  tag;
        word_t data;
    } line_t;

    typedef struct packed {
        logic      active;
        logic      write;
        logic      uncached;
        page_off_t off;
        be_t       be;
        word_t     wdata;
    } req_t;

    typedef struct packed {
        logic  hit;
        logic  miss;
        logic  upd;
        word_t rdata;
    } verdict_t;

    function automatic idx_t index_of(page_off_t off);
        return off[PAGE_BITS-1:OFFSET_BITS];
    endfunction

    function automatic paddr_t phys_addr(pfn_t pfn, page_off_t off);
        return {pfn, off};
    endfunction

endpackage

// File: rtl/vipt_store.sv
module vipt_store
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  fill_en,
    input  idx_t  fill_idx,
    input  pfn_t  fill_tag,
    input  word_t fill_data,
    input  logic  upd_en,
    input  idx_t  upd_idx,
    input  be_t   upd_be,
    input  word_t upd_data
);

    logic [SETS-1:0] valid_q;
    pfn_t            tag_mem [SETS];
    word_t           rd_word;
    logic            upd_blocked;

    // A fill to the same entry wins over a concurrent store hit.
    assign upd_blocked = fill_en && (fill_idx == upd_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_idx] <= fill_tag;
        end
    end

    for (genvar ln = 0; ln < WORD_BYTES; ln++) begin : g_lane
        logic [7:0] lane_mem [SETS];

        always_ff @(posedge clk) begin
            if (upd_en && upd_be[ln] && !upd_blocked) begin
                lane_mem[upd_idx] <= upd_data[8*ln +: 8];
            end
            if (fill_en) begin
                lane_mem[fill_idx] <= fill_data[8*ln +: 8];
            end
        end

        assign rd_word[8*ln +: 8] = lane_mem[rd_idx];
    end

    assign rd_line = '{valid: valid_q[rd_idx], tag: tag_mem[rd_idx], data: rd_word};

    // R1
    valid_clear_chk: assert property (@(posedge clk) rst |=> valid_q == '0);

    // R5
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(fill_idx)]);

    // R7
    no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> $stable(valid_q));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
(
    input  req_t     req,
    input  logic     xlat_ok,
    input  pfn_t     xlat_pfn,
    input  line_t    line,
    output verdict_t verdict
);

    logic tag_eq;
    logic cached_req;

    assign tag_eq     = (line.tag == xlat_pfn);
    assign cached_req = req.active && !req.uncached && xlat_ok;

    always_comb begin
        verdict.hit   = cached_req && line.valid && tag_eq;
        verdict.miss  = req.active && !verdict.hit;
        verdict.upd   = verdict.hit && req.write;
        verdict.rdata = verdict.hit ? line.data : '0;
    end

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_uncached,
    input  logic [PAGE_BITS-1:0]  req_vaddr_lo,
    input  logic [WORD_BYTES-1:0] req_be,
    input  logic [WORD_BITS-1:0]  req_wdata,
    input  logic                  tlb_hit,
    input  logic [PFN_BITS-1:0]   tlb_pfn,
    output logic [WORD_BITS-1:0]  rd_data,
    output logic                  hit,
    output logic                  miss,
    output logic                  mem_wr_valid,
    output logic [PADDR_BITS-1:0] mem_wr_addr,
    output logic [WORD_BYTES-1:0] mem_wr_be,
    output logic [WORD_BITS-1:0]  mem_wr_data,
    input  logic                  fill_valid,
    input  logic [INDEX_BITS-1:0] fill_index,
    input  logic [PFN_BITS-1:0]   fill_pfn,
    input  logic [WORD_BITS-1:0]  fill_data
);

    req_t     req;
    line_t    line;
    verdict_t verdict;
    idx_t     req_idx;

    assign req = '{active:   req_valid,
                   write:    req_write,
                   uncached: req_uncached,
                   off:      req_vaddr_lo,
                   be:       req_be,
                   wdata:    req_wdata};

    // Index comes from offset bits only: array read starts before translation.
    assign req_idx = index_of(req.off);

    vipt_store u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (req_idx),
        .rd_line   (line),
        .fill_en   (fill_valid),
        .fill_idx  (fill_index),
        .fill_tag  (fill_pfn),
        .fill_data (fill_data),
        .upd_en    (verdict.upd),
        .upd_idx   (req_idx),
        .upd_be    (req.be),
        .upd_data  (req.wdata)
    );

    vipt_lookup u_lookup (
        .req      (req),
        .xlat_ok  (tlb_hit),
        .xlat_pfn (tlb_pfn),
        .line     (line),
        .verdict  (verdict)
    );

    assign hit     = verdict.hit;
    assign miss    = verdict.miss;
    assign rd_data = verdict.rdata;

    // Write-through: every translated store goes to memory, cached or not.
    assign mem_wr_valid = req.active && req.write && tlb_hit;
    assign mem_wr_addr  = phys_addr(tlb_pfn, req.off);
    assign mem_wr_be    = req.be;
    assign mem_wr_data  = req.wdata;

    // R5
    fill_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fill_valid) && req_valid && !req_uncached && tlb_hit &&
         req_idx == $past(fill_index) && tlb_pfn == $past(fill_pfn))
        |-> (hit && rd_data == $past(fill_data)));

    // R9
    uncached_nohit_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_uncached) |-> !hit);

    // R4
    xlat_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !tlb_hit) |-> (!hit && !mem_wr_valid));

    // R11
    quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> rd_data == '0);

    // R12
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss));

endmodule

// File: tb/vipt_cache_bench.sv
`timescale 1ns/1ps
module vipt_cache_bench;
    import vipt_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_uncached;
    logic [11:0] req_vaddr_lo;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        tlb_hit;
    logic [19:0] tlb_pfn;
    logic [31:0] rd_data;
    logic        hit, miss;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [3:0]  mem_wr_be;
    logic [31:0] mem_wr_data;
    logic        fill_valid;
    logic [9:0]  fill_index;
    logic [19:0] fill_pfn;
    logic [31:0] fill_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vipt_cache u_vipt_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_uncached(req_uncached),
        .req_vaddr_lo(req_vaddr_lo), .req_be(req_be), .req_wdata(req_wdata),
        .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
        .rd_data(rd_data), .hit(hit), .miss(miss),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_be(mem_wr_be), .mem_wr_data(mem_wr_data),
        .fill_valid(fill_valid), .fill_index(fill_index),
        .fill_pfn(fill_pfn), .fill_data(fill_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_write = 0; req_uncached = 0; req_vaddr_lo = '0;
        req_be = '0; req_wdata = '0; tlb_hit = 0; tlb_pfn = '0;
        fill_valid = 0; fill_index = '0; fill_pfn = '0; fill_data = '0;
    endtask

    // One cycle: inputs set after the falling edge, outputs sampled 1 ns later.
    task automatic cyc_read(input logic [9:0] idx, input logic [1:0] bofs, input logic [19:0] pfn,
                            input bit th, input bit unc);
        @(negedge clk);
        idle_inputs();
        req_valid = 1; req_vaddr_lo = {idx, bofs}; tlb_hit = th; tlb_pfn = pfn; req_uncached = unc;
        #1;
    endtask

    task automatic cyc_write(input logic [9:0] idx, input logic [19:0] pfn, input logic [3:0] be,
                             input logic [31:0] d, input bit th, input bit unc);
        @(negedge clk);
        idle_inputs();
        req_valid = 1; req_write = 1; req_vaddr_lo = {idx, 2'b00}; req_be = be;
        req_wdata = d; tlb_hit = th; tlb_pfn = pfn; req_uncached = unc;
        #1;
    endtask

    task automatic cyc_fill(input logic [9:0] idx, input logic [19:0] pfn, input logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        fill_valid = 1; fill_index = idx; fill_pfn = pfn; fill_data = d;
        #1;
    endtask

    task automatic t_reset_state();
        @(negedge clk); idle_inputs(); #1;
        chk_eq("R12 idle hit", {31'b0, hit}, 32'd0);
        chk_eq("R12 idle miss", {31'b0, miss}, 32'd0);
        cyc_read(10'h005, 2'd0, 20'h00000, 1, 0);
        chk_eq("R1 miss after reset", {31'b0, miss}, 32'd1);
        chk_eq("R11 data zero on miss", rd_data, 32'd0);
    endtask

    task automatic t_fill_then_read();
        cyc_fill(10'h012, 20'hABCDE, 32'h11223344);
        cyc_read(10'h012, 2'd3, 20'hABCDE, 1, 0);
        chk_eq("R5 next-cycle hit", {31'b0, hit}, 32'd1);
        chk_eq("R5 next-cycle data", rd_data, 32'h11223344);
        cyc_read(10'h012, 2'd1, 20'hABCDE, 1, 0);
        chk_eq("R2 byte offset same word", rd_data, 32'h11223344);
        cyc_read(10'h013, 2'd0, 20'hABCDE, 1, 0);
        chk_eq("R2 neighbour index misses", {31'b0, miss}, 32'd1);
    endtask

    task automatic t_tag_and_xlat();
        cyc_read(10'h012, 2'd0, 20'hABCDF, 1, 0);
        chk_eq("R3 frame mismatch miss", {31'b0, miss}, 32'd1);
        chk_eq("R3 frame mismatch hit", {31'b0, hit}, 32'd0);
        cyc_read(10'h012, 2'd0, 20'hABCDE, 0, 0);
        chk_eq("R4 translation miss", {31'b0, miss}, 32'd1);
        chk_eq("R4 no data", rd_data, 32'd0);
    endtask

    task automatic t_store_hit();
        cyc_write(10'h012, 20'hABCDE, 4'b0101, 32'hA1B2C3D4, 1, 0);
        chk_eq("R8 forwarded valid", {31'b0, mem_wr_valid}, 32'd1);
        chk_eq("R8 forwarded addr", mem_wr_addr, 32'hABCDE048);
        chk_eq("R8 forwarded be", {28'b0, mem_wr_be}, 32'h5);
        chk_eq("R8 forwarded data", mem_wr_data, 32'hA1B2C3D4);
        cyc_read(10'h012, 2'd0, 20'hABCDE, 1, 0);
        chk_eq("R6 byte-masked update", rd_data, 32'h11B233D4);
    endtask

    task automatic t_store_miss();
        cyc_write(10'h040, 20'h00001, 4'hF, 32'h55667788, 1, 0);
        chk_eq("R8 miss store forwarded", {31'b0, mem_wr_valid}, 32'd1);
        chk_eq("R8 miss store addr", mem_wr_addr, 32'h00001100);
        cyc_read(10'h040, 2'd0, 20'h00001, 1, 0);
        chk_eq("R7 no allocate", {31'b0, miss}, 32'd1);
        cyc_write(10'h012, 20'hABCDE, 4'hF, 32'h0, 0, 0);
        chk_eq("R8 no forward on translation miss", {31'b0, mem_wr_valid}, 32'd0);
        cyc_read(10'h012, 2'd0, 20'hABCDE, 1, 0);
        chk_eq("R4 translation-miss store no update", rd_data, 32'h11B233D4);
    endtask

    task automatic t_uncached();
        cyc_read(10'h012, 2'd0, 20'hABCDE, 1, 1);
        chk_eq("R9 uncached read misses", {31'b0, miss}, 32'd1);
        cyc_write(10'h012, 20'hABCDE, 4'hF, 32'h00000000, 1, 1);
        chk_eq("R9 uncached store forwarded", {31'b0, mem_wr_valid}, 32'd1);
        chk_eq("R9 uncached store no hit", {31'b0, hit}, 32'd0);
        cyc_read(10'h012, 2'd0, 20'hABCDE, 1, 0);
        chk_eq("R9 array untouched", rd_data, 32'h11B233D4);
    endtask

    task automatic t_collision();
        cyc_fill(10'h020, 20'h00005, 32'h01010101);
        @(negedge clk);
        idle_inputs();
        fill_valid = 1; fill_index = 10'h020; fill_pfn = 20'h00005; fill_data = 32'hCAFEF00D;
        req_valid = 1; req_write = 1; req_vaddr_lo = {10'h020, 2'b00}; req_be = 4'hF;
        req_wdata = 32'hDEADBEEF; tlb_hit = 1; tlb_pfn = 20'h00005;
        #1;
        chk_eq("R10 store is a hit", {31'b0, hit}, 32'd1);
        cyc_read(10'h020, 2'd0, 20'h00005, 1, 0);
        chk_eq("R10 fill wins", rd_data, 32'hCAFEF00D);
    endtask

    task automatic t_index_extremes();
        cyc_fill(10'h3FF, 20'h12345, 32'hFEEDFACE);
        cyc_fill(10'h000, 20'h12345, 32'h0BADC0DE);
        cyc_read(10'h3FF, 2'd2, 20'h12345, 1, 0);
        chk_eq("R2 top index", rd_data, 32'hFEEDFACE);
        cyc_read(10'h000, 2'd0, 20'h12345, 1, 0);
        chk_eq("R2 bottom index", rd_data, 32'h0BADC0DE);
        cyc_fill(10'h000, 20'h54321, 32'h12121212);
        cyc_read(10'h000, 2'd0, 20'h12345, 1, 0);
        chk_eq("R3 refill replaces tag", {31'b0, miss}, 32'd1);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset_state();
        t_fill_then_read();
        t_tag_and_xlat();
        t_store_hit();
        t_store_miss();
        t_uncached();
        t_collision();
        t_index_extremes();
        @(negedge clk);
        idle_inputs();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule